// File: doc/BRIEF.md
# Four-slot pulse position frame transmitter

This block serialises a frame for a 4 Mb/s infrared link that uses four-slot pulse position modulation. Every chip is four timeslots long and the block emits one timeslot per clock on a single active-high line. At the intended 8 MHz slot clock one slot lasts 125 ns, so each 500 ns chip carries two data bits.

A start pulse launches a frame. The block first sends the fixed lead-in pattern and then the opening flag. It then pulls payload bytes through a valid/ready handshake, and the byte that carries the end marker closes the payload. After the payload come four bytes of a check value that has already been computed, and the frame ends with the closing flag. The lead-in and the two flags contain chips with zero or two pulses, which ordinary data can never produce. If the source has no byte ready when one is needed, the frame is cut short. The block flags an underrun and finishes the frame with the closing flag.

The address byte, the optional control byte and the data all enter through the same byte port; the block does not tell them apart. Computing the check value, the optical driver and the receive side belong to other blocks.

Top module: `ppm4_frame_tx`

## Requirements
- R1: After reset and whenever no frame is running, `line_o`, `ready_o` and `busy_o` are low.
- R2: A `start_i` pulse while idle starts a frame: `busy_o` is high in the next cycle and the first slot of the lead-in appears on `line_o` in that same cycle. A `start_i` pulse while a frame is running has no effect on the emitted stream.
- R3: `line_o` carries one timeslot per clock. A chip is sent left to right, one slot per cycle, with '1' meaning a pulse.
- R4: The lead-in is the four-chip group 1000 0000 1010 1000, sent PRE_REPEAT times (16 by default), 64 chips in total.
- R5: The opening flag follows the lead-in and is the eight chips 0000 1100 0000 1100 0110 0000 0110 0000.
- R6: Each payload byte becomes four data chips, taking bits [1:0] first, then [3:2], [5:4] and [7:6]. A dibit of value d becomes the chip 1000 shifted right by d (00→1000, 01→0100, 10→0010, 11→0001), so every data chip holds exactly one pulse.
- R7: `ready_o` is high for exactly one cycle, in the last slot of the opening flag and in the last slot of every payload byte that did not carry `byte_last_i`. A byte is taken when `byte_valid_i` and `ready_o` are both high.
- R8: After the byte marked by `byte_last_i`, the block sends `crc_i` as 16 data chips. `crc_i` is sampled in the final slot of that byte. The least significant byte goes first, and its dibits are ordered as in R6.
- R9: The frame ends with the closing flag 0000 1100 0000 1100 0000 0110 0000 0110. The block is idle in the cycle after the flag's last slot.
- R10: If `byte_valid_i` is low while `ready_o` is high, the check value is skipped and the closing flag follows at once. `underrun_o` then goes high and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one timeslot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a frame (acted on only when idle) |
| byte_valid_i | input | 1 | Payload byte present |
| byte_data_i | input | 8 | Payload byte |
| byte_last_i | input | 1 | This byte is the final payload byte |
| crc_i | input | 32 | Precomputed check value, sampled after the final byte |
| ready_o | output | 1 | Block takes a byte in this cycle |
| line_o | output | 1 | Modulated serial output, active high |
| busy_o | output | 1 | A frame is in progress |
| underrun_o | output | 1 | Last frame was cut short by a missing byte |

## Verification
The hardest case to reach is a payload that runs dry: at the one-cycle ready window the source must be empty, and the stream must then change at once from data chips to the closing flag without sending the check value. The bench gets there by giving the byte source a fixed number of bytes and withholding the end marker. It does this once with two bytes and once with none, so the dry point falls at the end of a data byte and also right after the opening flag. A second start is pulsed in the middle of a frame, and the slot-by-slot scoreboard shows that the stream did not change.

// File: rtl/ppm4_pkg.sv
package ppm4_pkg;

    typedef logic [3:0] chip_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOF,
        PH_DATA,
        PH_CRC,
        PH_EOF
    } phase_e;

    // Lead-in group written twice so every flag indexes eight chips.
    localparam logic [31:0] LEADIN_X2 = 32'b1000_0000_1010_1000_1000_0000_1010_1000;
    localparam logic [31:0] OPEN_FLAG = 32'b0000_1100_0000_1100_0110_0000_0110_0000;
    localparam logic [31:0] CLOSE_FLAG = 32'b0000_1100_0000_1100_0000_0110_0000_0110;

    // Chip idx of an eight-chip pattern, leftmost chip is index 0.
    function automatic chip_t flag_chip(input logic [31:0] pat, input logic [2:0] idx);
        return pat[(7 - int'(idx)) * 4 +: 4];
    endfunction

    // One pulse, position selected by the dibit value.
    function automatic chip_t dibit_chip(input logic [1:0] d);
        return chip_t'(4'b1000 >> d);
    endfunction

endpackage

// File: rtl/ppm4_slot_timer.sv
module ppm4_slot_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    output logic [1:0]       slot,
    output logic [CNT_W-1:0] chip_idx,
    output logic             chip_end
);

    assign chip_end = run && (slot == 2'd3);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            slot     <= 2'd0;
            chip_idx <= '0;
        end else begin
            slot <= slot + 2'd1;
            if (chip_end) begin
                chip_idx <= restart ? '0 : chip_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppm4_chip_gen.sv
module ppm4_chip_gen
    import ppm4_pkg::*;
(
    input  phase_e      phase,
    input  logic [2:0]  idx,
    input  logic [1:0]  dibit,
    output chip_t       chip
);

    always_comb begin
        unique case (phase)
            PH_PRE:  chip = flag_chip(LEADIN_X2, idx);
            PH_SOF:  chip = flag_chip(OPEN_FLAG, idx);
            PH_DATA,
            PH_CRC:  chip = dibit_chip(dibit);
            PH_EOF:  chip = flag_chip(CLOSE_FLAG, idx);
            default: chip = '0;
        endcase
    end

endmodule

// File: rtl/ppm4_dibit_shreg.sv
module ppm4_dibit_shreg #(
    parameter int BYTE_W = 8,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_byte,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              load_crc,
    input  logic [CRC_W-1:0]  crc_in,
    input  logic              shift,
    output logic [1:0]        dibit
);

    logic [CRC_W-1:0] sh_q;

    assign dibit = sh_q[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load_byte) begin
            sh_q <= CRC_W'(byte_in);
        end else if (load_crc) begin
            sh_q <= crc_in;
        end else if (shift) begin
            sh_q <= sh_q >> 2;
        end
    end

endmodule

// File: rtl/ppm4_frame_tx.sv
module ppm4_frame_tx
    import ppm4_pkg::*;
#(
    parameter int PRE_REPEAT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_data_i,
    input  logic        byte_last_i,
    input  logic [31:0] crc_i,
    output logic        ready_o,
    output logic        line_o,
    output logic        busy_o,
    output logic        underrun_o
);

    localparam int PRE_CHIPS = 4 * PRE_REPEAT;
    localparam int CNT_W     = $clog2(PRE_CHIPS > 16 ? PRE_CHIPS : 16);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CHIPS - 1);

    phase_e           phase_q, phase_n;
    logic [1:0]       slot;
    logic [CNT_W-1:0] chip_idx;
    logic             chip_end;
    logic             last_q;
    logic             under_q;
    logic             load_b, load_c, set_ur;
    logic [1:0]       dibit;
    chip_t            chip;

    ppm4_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (phase_q != PH_IDLE),
        .restart  (phase_n != phase_q),
        .slot     (slot),
        .chip_idx (chip_idx),
        .chip_end (chip_end)
    );

    ppm4_dibit_shreg #(.BYTE_W(8), .CRC_W(32)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load_byte (load_b),
        .byte_in   (byte_data_i),
        .load_crc  (load_c),
        .crc_in    (crc_i),
        .shift     (chip_end && (phase_q == PH_DATA || phase_q == PH_CRC)),
        .dibit     (dibit)
    );

    ppm4_chip_gen u_gen (
        .phase (phase_q),
        .idx   (chip_idx[2:0]),
        .dibit (dibit),
        .chip  (chip)
    );

    always_comb begin
        phase_n = phase_q;
        load_b  = 1'b0;
        load_c  = 1'b0;
        set_ur  = 1'b0;
        ready_o = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (start_i) phase_n = PH_PRE;
            PH_PRE:  if (chip_end && chip_idx == PRE_LAST) phase_n = PH_SOF;
            PH_SOF: begin
                if (chip_end && chip_idx[2:0] == 3'd7) begin
                    ready_o = 1'b1;
                    if (byte_valid_i) begin
                        phase_n = PH_DATA;
                        load_b  = 1'b1;
                    end else begin
                        phase_n = PH_EOF;
                        set_ur  = 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (chip_end && chip_idx[1:0] == 2'd3) begin
                    if (last_q) begin
                        phase_n = PH_CRC;
                        load_c  = 1'b1;
                    end else begin
                        ready_o = 1'b1;
                        if (byte_valid_i) begin
                            load_b = 1'b1;
                        end else begin
                            phase_n = PH_EOF;
                            set_ur  = 1'b1;
                        end
                    end
                end
            end
            PH_CRC:  if (chip_end && chip_idx[3:0] == 4'd15) phase_n = PH_EOF;
            PH_EOF:  if (chip_end && chip_idx[2:0] == 3'd7) phase_n = PH_IDLE;
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            last_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            phase_q <= phase_n;
            if (load_b) last_q <= byte_last_i;
            if (phase_q == PH_IDLE && start_i) under_q <= 1'b0;
            else if (set_ur)                   under_q <= 1'b1;
        end
    end

    assign busy_o     = (phase_q != PH_IDLE);
    assign line_o     = busy_o && chip[~slot];
    assign underrun_o = under_q;

endmodule

// File: rtl/ppm4_tx_checker.sv
module ppm4_tx_checker
    import ppm4_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   start_i,
    input logic   byte_valid_i,
    input logic   ready_o,
    input logic   line_o,
    input logic   busy_o,
    input logic   underrun_o,
    input phase_e phase,
    input logic [1:0] slot
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!line_o && !ready_o));

    a_r2_start_launch: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_DATA || phase == PH_CRC) && slot == 2'd3) |->
        ($countones({$past(line_o, 3), $past(line_o, 2), $past(line_o, 1), line_o}) == 1));

    a_r7_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> busy_o);

    a_r10_underrun_flag: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !byte_valid_i) |=> (underrun_o && busy_o));

endmodule

bind ppm4_frame_tx ppm4_tx_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .ready_o      (ready_o),
    .line_o       (line_o),
    .busy_o       (busy_o),
    .underrun_o   (underrun_o),
    .phase        (phase_q),
    .slot         (slot)
);

// File: tb/tb_ppm4_frame_tx.sv
module tb_ppm4_frame_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        byte_valid_i;
    logic [7:0]  byte_data_i;
    logic        byte_last_i;
    logic [31:0] crc_i = '0;
    logic        ready_o, line_o, busy_o, underrun_o;

    int n_checks = 0;
    int n_fail   = 0;

    // byte source
    logic [7:0] feed_mem [8];
    int  feed_n   = 0;
    int  feed_idx = 0;
    bit  mark_last = 1'b0;
    bit  took = 1'b0;

    // scoreboard
    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ppm4_frame_tx dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_data_i  (byte_data_i),
        .byte_last_i  (byte_last_i),
        .crc_i        (crc_i),
        .ready_o      (ready_o),
        .line_o       (line_o),
        .busy_o       (busy_o),
        .underrun_o   (underrun_o)
    );

    always_comb begin
        byte_valid_i = (feed_idx < feed_n);
        byte_data_i  = feed_mem[feed_idx[2:0]];
        byte_last_i  = mark_last && (feed_idx == feed_n - 1);
    end

    // ready/valid seen in this cycle means the coming edge takes the byte
    always @(negedge clk) begin
        if (took) feed_idx = feed_idx + 1;
        took = ready_o && (feed_idx < feed_n);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_chip(input logic [3:0] c, input string tag);
        for (int s = 3; s >= 0; s--) begin
            exp_q.push_back(c[s]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_flag(input logic [31:0] pat, input string tag);
        for (int i = 7; i >= 0; i--) push_chip(pat[i*4 +: 4], tag);
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        for (int k = 0; k < 4; k++) push_chip(4'b1000 >> b[2*k +: 2], tag);
    endtask

    task automatic build(input bit with_crc);
        for (int g = 0; g < 16; g++) begin
            push_chip(4'b1000, "R4 lead-in");
            push_chip(4'b0000, "R4 lead-in");
            push_chip(4'b1010, "R4 lead-in");
            push_chip(4'b1000, "R4 lead-in");
        end
        push_flag(32'b0000_1100_0000_1100_0110_0000_0110_0000, "R5 open flag");
        for (int i = 0; i < feed_n; i++) push_byte(feed_mem[i], "R6 payload");
        if (with_crc)
            for (int i = 0; i < 4; i++) push_byte(crc_i[8*i +: 8], "R8 check value");
        push_flag(32'b0000_1100_0000_1100_0000_0110_0000_0110, "R9 close flag");
    endtask

    task automatic run_frame(input int inject_at, input bit exp_under);
        int n = 0;
        bit e;
        string t;
        build(!exp_under);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(line_o === e, {t, " R3 slot"}, int'(line_o), int'(e));
            start_i = (n == inject_at);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk(busy_o === 1'b0, "R9 idle after close flag", int'(busy_o), 0);
        chk(line_o === 1'b0, "R1 line low when idle", int'(line_o), 0);
        chk(underrun_o === exp_under, "R10 underrun flag", int'(underrun_o), int'(exp_under));
        chk(feed_idx == feed_n, "R7 bytes taken", feed_idx, feed_n);
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0, "R1 stays idle", int'(busy_o), 0);
    endtask

    task automatic setup(input int n, input bit last, input logic [31:0] crc);
        feed_n    = n;
        feed_idx  = 0;
        mark_last = last;
        crc_i     = crc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) feed_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(line_o === 1'b0, "R1 reset line", int'(line_o), 0);
        chk(ready_o === 1'b0, "R1 reset ready", int'(ready_o), 0);
        chk(busy_o === 1'b0, "R1 reset busy", int'(busy_o), 0);
        chk(underrun_o === 1'b0, "R10 reset underrun", int'(underrun_o), 0);

        // Frame 1: all four dibit values, three bytes
        feed_mem[0] = 8'hE4; feed_mem[1] = 8'h1B; feed_mem[2] = 8'h00;
        setup(3, 1'b1, 32'hA5C3_0F96);
        run_frame(-1, 1'b0);

        // Frame 2: one byte, second start injected mid-frame (R2 ignored)
        feed_mem[0] = 8'hFF;
        setup(1, 1'b1, 32'h1234_5678);
        run_frame(100, 1'b0);

        // Frame 3: source runs dry after two bytes (R10)
        feed_mem[0] = 8'h5A; feed_mem[1] = 8'hC3;
        setup(2, 1'b0, 32'hFFFF_FFFF);
        run_frame(-1, 1'b1);

        // Frame 4: source empty right after the open flag (R10)
        setup(0, 1'b0, 32'h0);
        run_frame(-1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule